// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a receive path. It looks at the first six bytes of each incoming frame, the destination address, and issues one accept or reject decision per frame. Bytes arrive one per valid cycle. The first byte of a frame is flagged by a start marker, and the first byte received is byte 0 of the address.

Four rules decide the frame, checked in priority order. Promiscuous mode accepts every frame. An all-ones address is broadcast, which a mode bit either accepts or rejects. Any other address with the group bit set is multicast, and a 64-bit hash table indexed by bits of a CRC-32 over the address decides it. A remaining unicast address must equal the programmed station address.

The station address, the hash table and the mode bits are written and read through a small 32-bit register port. Frame storage is left to the surrounding logic.

Top module: `dest_addr_filter`

## Requirements
- R1: Register index 0 holds address bytes 2,3,4,5 in bits 31:24, 23:16, 15:8 and 7:0. Index 1 holds byte 0 in bits 15:8 and byte 1 in bits 7:0, and bits 31:16 read as zero. Index 2 holds hash bits 31:0 and index 3 holds hash bits 63:32. Index 4 bit 0 is the reject-broadcast bit and bit 1 is the promiscuous bit; its other bits read as zero. Indexes 5 to 7 read zero. A write takes effect at the clock edge, and a read returns the stored value combinationally.
- R2: After reset every register reads zero and decisionValid is low.
- R3: A unicast frame is one whose byte 0 has bit 0 clear. It is accepted only when all six bytes equal the station address of R1.
- R4: A broadcast frame is one whose six bytes are all 0xFF. It is rejected when the reject-broadcast bit is 1 and accepted when that bit is 0.
- R5: When the promiscuous bit is 1, every frame is accepted.
- R6: A multicast frame is one whose byte 0 has bit 0 set and which is not broadcast. A CRC is run over the six bytes in arrival order, each byte least significant bit first. The CRC uses polynomial 0x04C11DB7, shifts toward bit 31, starts at all ones and applies no final inversion. Its bits 31:26 form a 6-bit index. Index bit 5 selects hash index 3 (when 1) or hash index 2 (when 0), and index bits 4:0 select the bit in that word. The frame is accepted when that bit is 1.
- R7: decisionValid is high for exactly one cycle, the cycle after the clock edge that takes the sixth address byte. accept is valid in that cycle.
- R8: A byte with frameStart set always begins a new address, even partway through one. Valid bytes after the sixth byte and before the next frameStart do not change any decision. Bytes seen after reset and before the first frameStart are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A receive byte is present this cycle |
| frameStart | input | 1 | With byteValid, marks byte 0 of a new frame |
| byteData | input | 8 | Receive byte |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| decisionValid | output | 1 | One-cycle pulse carrying the frame decision |
| accept | output | 1 | Frame accepted (when decisionValid is high) |

## Verification
Reaching a chosen hash bucket from the ports is the hardest part to arrange. The bench computes the CRC index of a chosen multicast address itself. It first runs that address with an empty table, then sets only the computed bit, then fills the table with ones. A wrong bit order, word select or CRC shift direction therefore shows up as a wrong decision.

The bench also restarts a frame partway through an address and sends trailing bytes and gapped bytes. This shows that the position counter restarts on frameStart and stops after the sixth byte. A per-cycle reference model checks every decision pulse.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int POS_W = $clog2(ADDR_BYTES + 1);

  typedef struct packed {
    logic take;
    logic first;
    logic [POS_W-1:0] pos;
  } strobe_t;
endpackage

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    byteValid,
  input  logic    frameStart,
  output strobe_t strb,
  output logic    done
);
  logic [POS_W-1:0] count;
  logic [POS_W-1:0] pos;
  logic take, last;

  always_comb begin
    pos  = frameStart ? '0 : count;
    take = byteValid && (frameStart || (count < POS_W'(ADDR_BYTES)));
    last = take && (pos == POS_W'(ADDR_BYTES - 1));
    strb.take  = take;
    strb.first = byteValid && frameStart;
    strb.pos   = pos;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= POS_W'(ADDR_BYTES);
      done  <= 1'b0;
    end else begin
      done <= last;
      if (take) count <= pos + 1'b1;
    end
  end

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ignore_extra_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byteValid && !frameStart && count == POS_W'(ADDR_BYTES)) |=>
      (count == POS_W'(ADDR_BYTES) && !done));
endmodule

// File: rtl/daf_datapath.sv
module daf_datapath
  import daf_pkg::*;
#(
  parameter int REG_W = 32,
  parameter logic [31:0] POLY = 32'h04C11DB7,
  parameter int HASH_IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [7:0]       byteData,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             accept,
  output logic             bcastSeen,
  output logic             groupSeen,
  output logic [1:0]       modeOut,
  output logic             hashEmpty
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam int HIGH_BYTES = ADDR_BYTES - 4;

  logic [REG_W-1:0] stationLo, hashLo, hashHi;
  logic [8*HIGH_BYTES-1:0] stationHi;
  logic [1:0] modeReg;
  logic [31:0] crcReg;
  logic matchReg, onesReg, groupReg;
  logic [AW-1:0] stationAll;
  logic [7:0] stationByte;
  logic [HASH_IDX_W-1:0] hashIdx;
  logic hashBit;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_comb begin
    stationAll  = {stationHi, stationLo};
    stationByte = stationAll[8*(ADDR_BYTES-1-int'(strb.pos)) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stationLo <= '0;
      stationHi <= '0;
      hashLo    <= '0;
      hashHi    <= '0;
      modeReg   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        3'd0: stationLo <= regWrData;
        3'd1: stationHi <= regWrData[8*HIGH_BYTES-1:0];
        3'd2: hashLo    <= regWrData;
        3'd3: hashHi    <= regWrData;
        3'd4: modeReg   <= regWrData[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crcReg   <= '1;
      matchReg <= 1'b0;
      onesReg  <= 1'b0;
      groupReg <= 1'b0;
    end else if (strb.take) begin
      crcReg   <= crcByte(strb.first ? 32'hFFFF_FFFF : crcReg, byteData);
      matchReg <= (strb.first || matchReg) && (byteData == stationByte);
      onesReg  <= (strb.first || onesReg) && (byteData == 8'hFF);
      if (strb.first) groupReg <= byteData[0];
    end
  end

  always_comb begin
    hashIdx = crcReg[31 -: HASH_IDX_W];
    hashBit = hashIdx[HASH_IDX_W-1] ? hashHi[hashIdx[HASH_IDX_W-2:0]]
                                    : hashLo[hashIdx[HASH_IDX_W-2:0]];
    if (modeReg[1])    accept = 1'b1;
    else if (onesReg)  accept = !modeReg[0];
    else if (groupReg) accept = hashBit;
    else               accept = matchReg;
  end

  always_comb begin
    case (regAddr)
      3'd0: regRdData = stationLo;
      3'd1: regRdData = REG_W'(stationHi);
      3'd2: regRdData = hashLo;
      3'd3: regRdData = hashHi;
      3'd4: regRdData = REG_W'(modeReg);
      default: regRdData = '0;
    endcase
  end

  assign bcastSeen = onesReg;
  assign groupSeen = groupReg;
  assign modeOut   = modeReg;
  assign hashEmpty = (hashLo == '0) && (hashHi == '0);
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byteValid,
  input  logic        frameStart,
  input  logic [7:0]  byteData,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        decisionValid,
  output logic        accept
);
  strobe_t strb;
  logic bcastSeen, groupSeen, hashEmpty;
  logic [1:0] modeOut;

  daf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .frameStart(frameStart),
    .strb(strb), .done(decisionValid)
  );

  daf_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .byteData(byteData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .accept(accept), .bcastSeen(bcastSeen),
    .groupSeen(groupSeen), .modeOut(modeOut), .hashEmpty(hashEmpty)
  );

  assert_promisc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decisionValid && modeOut[1]) |-> accept);

  assert_bcast_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (decisionValid && !modeOut[1] && bcastSeen && modeOut[0]) |-> !accept);

  assert_empty_hash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (decisionValid && !modeOut[1] && !bcastSeen && groupSeen && hashEmpty) |-> !accept);
endmodule

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic byteValid = 0, frameStart = 0, regWrEn = 0;
  logic [7:0] byteData = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic decisionValid, accept;

  int checks = 0, errors = 0;
  string curTag = "R2";
  bit finished = 0;

  // reference model state
  logic [31:0] mReg[5];
  logic [7:0]  mBuf[6];
  int mCnt = 0;
  bit expDv = 0, expAcc = 0;

  always #2.5 clk = ~clk;

  dest_addr_filter u_dest_addr_filter (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .frameStart(frameStart),
    .byteData(byteData), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .decisionValid(decisionValid), .accept(accept)
  );

  function automatic logic [31:0] refCrc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] d = a[47-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        bit top = c[31] ^ d[i];
        c = c << 1;
        if (top) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic bit refDecide();
    logic [47:0] a;
    logic [63:0] h;
    int idx;
    for (int i = 0; i < 6; i++) a[47-8*i -: 8] = mBuf[i];
    h = {mReg[3], mReg[2]};
    if (mReg[4][1]) return 1;
    if (a == 48'hFFFF_FFFF_FFFF) return !mReg[4][0];
    if (a[40]) begin
      idx = int'(refCrc(a) >> 26);
      return h[idx];
    end
    return a == {mReg[1][15:0], mReg[0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) mReg[i] = 0;
      mCnt = 0; expDv = 0;
    end else begin
      if (regWrEn && regAddr < 5) mReg[regAddr] = regWrData;
      expDv = 0;
      if (byteValid) begin
        if (frameStart) begin mBuf[0] = byteData; mCnt = 1; end
        else if (mCnt >= 1 && mCnt < 6) begin mBuf[mCnt] = byteData; mCnt++;
          if (mCnt == 6) expDv = 1;
        end
      end
      if (expDv) expAcc = refDecide();
    end
  end

  always @(negedge clk) begin
    if (rst_n && (expDv || decisionValid)) begin
      checks++;
      if (decisionValid !== expDv || (expDv && accept !== expAcc)) begin
        errors++;
        $display("FAIL %s decision: valid=%0b accept=%0b expected valid=%0b accept=%0b",
                 curTag, decisionValid, accept, expDv, expAcc);
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d; step(); regWrEn = 0;
  endtask

  task automatic rdCheck(input logic [2:0] a, input logic [31:0] e, input string tag);
    regAddr = a; #1;
    checks++;
    if (regRdData !== e) begin
      errors++;
      $display("FAIL %s read idx %0d: actual %h expected %h", tag, a, regRdData, e);
    end
  endtask

  task automatic sendAddr(input logic [47:0] a, input int gap, input int trail);
    for (int i = 0; i < 6; i++) begin
      byteValid = 1; frameStart = (i == 0); byteData = a[47-8*i -: 8]; step();
      byteValid = 0; frameStart = 0;
      for (int g = 0; g < gap; g++) step();
    end
    for (int t = 0; t < trail; t++) begin
      byteValid = 1; byteData = 8'hFF ^ 8'(t); step();
    end
    byteValid = 0; step(); step();
  endtask

  task automatic setStation(input logic [47:0] a);
    wr(3'd0, a[31:0]); wr(3'd1, {16'h0, a[47:32]});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] st, mc;
    int idx;
    st = 48'h0A1B2C3D4E5F;
    mc = 48'h01005E0A0B0C;
    step(); step();
    // bytes during reset-release before any start marker must be ignored (R8)
    rst_n = 1; #1;
    checks++;
    if (decisionValid !== 0) begin errors++; $display("FAIL R2 decisionValid=%0b expected 0", decisionValid); end
    for (int i = 0; i < 5; i++) rdCheck(3'(i), 32'h0, "R2");
    curTag = "R8";
    for (int i = 0; i < 8; i++) begin byteValid = 1; byteData = 8'(i); step(); end
    byteValid = 0; step(); step();

    // R1 register map
    setStation(st);
    rdCheck(3'd0, 32'h2C3D4E5F, "R1");
    rdCheck(3'd1, 32'h00000A1B, "R1");
    wr(3'd4, 32'hFFFF_FFFC);
    rdCheck(3'd4, 32'h0, "R1");
    wr(3'd5, 32'h1234_5678);
    rdCheck(3'd5, 32'h0, "R1");

    // R3 unicast
    curTag = "R3"; sendAddr(st, 0, 0);
    sendAddr(st ^ 48'h1, 0, 2);
    sendAddr(st ^ 48'h0200_0000_0000, 1, 0);
    sendAddr(48'h0, 0, 0);

    // R4 broadcast
    curTag = "R4"; sendAddr(48'hFFFF_FFFF_FFFF, 0, 0);
    wr(3'd4, 32'h1); sendAddr(48'hFFFF_FFFF_FFFF, 0, 0);
    sendAddr(st, 0, 0);

    // R6 multicast hash
    curTag = "R6"; wr(3'd4, 32'h0);
    sendAddr(mc, 0, 0);
    idx = int'(refCrc(mc) >> 26);
    if (idx >= 32) wr(3'd3, 32'h1 << (idx - 32)); else wr(3'd2, 32'h1 << idx);
    sendAddr(mc, 0, 0);
    sendAddr(mc ^ 48'h0000_0000_0100, 0, 0);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    sendAddr(48'h3300_0000_0001, 2, 0);
    sendAddr(mc, 0, 0);
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    sendAddr(48'h0100_5E7F_FFFA, 0, 0);

    // R5 promiscuous
    curTag = "R5"; wr(3'd4, 32'h3);
    sendAddr(48'h0200_0000_0077, 0, 0);
    sendAddr(48'hFFFF_FFFF_FFFF, 0, 0);
    sendAddr(mc, 0, 0);
    wr(3'd4, 32'h0);

    // R8 restart midway and back-to-back frames
    curTag = "R8";
    for (int i = 0; i < 3; i++) begin
      byteValid = 1; frameStart = (i == 0); byteData = 8'h55; step();
    end
    frameStart = 0; byteValid = 0;
    sendAddr(st, 0, 4);
    curTag = "R7";
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 6; i++) begin
        byteValid = 1; frameStart = (i == 0);
        byteData = (f == 1) ? 8'h77 : st[47-8*i -: 8]; step();
      end
    byteValid = 0; frameStart = 0; step(); step(); step();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule